// File: doc/BRIEF.md
# GPIO Pin Configuration Register Bank

This block is the register file of a general-purpose I/O controller. A plain 32-bit bus reads and writes it. Each write presents an address, a write strobe and a data word. The read data follows the address combinationally. Every pin has two configuration words. The first holds the pin's use (native function or GPIO), its direction, the level to drive and a read-only view of the sampled pad input. The second holds the input-sensing disable and the weak-pull selection. A separate ownership bitmap, packed 32 pins per word, comes from strap inputs. It tells software which pins firmware has reserved.

The block drives the pad output, the output enable and the pull selection directly from the stored configuration. Each pad input passes through a two-flop synchronizer before it can be read. The interrupt status, interrupt enable and interrupt routing words are handled elsewhere. Their addresses read as zero here.

Top module: `pin_cfg_regbank`

## Requirements
- R1: After reset, every pin's first and second configuration words both read 0x0000_0004. This means native use, input direction, drive level 0, sensing disabled and pull 0. All pad output enables and pad outputs are 0.
- R2: The first configuration word of pin p sits at 0x100 + 8*p. Bit 31 is the drive level, bit 2 is the direction (1 = input) and bits 1:0 are the use select (1 = GPIO). These fields read back as written, and bits 29:3 read 0.
- R3: The second configuration word of pin p sits at 0x104 + 8*p. Bit 2 disables input sensing and bits 1:0 hold the pull selection. Both read back as written, and bits 31:3 read 0. The pull selection of pin p drives pad_pull[2p+1:2p].
- R4: pad_oe[p] is 1 exactly when pin p's use select is 1 and its direction bit is 0. pad_out[p] then equals the drive level; otherwise it is 0. Both follow the configuration on the clock edge that writes it.
- R5: Bit 30 of the first configuration word shows the pad input after two clock edges of synchronization while sensing is enabled. It reads 0 while sensing is disabled.
- R6: A bus write to bit 30 of a first configuration word has no effect on the value read there.
- R7: Ownership words sit at 0x00, 0x04 and 0x08, and bit p%32 of word p/32 belongs to pin p. They take the value of own_strap on the first clock edge after reset and ignore bus writes.
- R8: Bits of the last ownership word beyond the highest pin read 0.
- R9: Addresses outside the ownership and configuration words read 0, and writes to them change nothing. This covers the interrupt words at 0x7C to 0x9C, anything from 0x100 + 8*NUM_PINS upward and any address with bits 1:0 nonzero.
- R10: Use-select values 2 and 3 are stored and read back, but they never enable the pad driver.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, acts on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| own_strap | input | NUM_PINS | Ownership pattern captured after reset, 0 = reserved |
| pad_in | input | NUM_PINS | Asynchronous pad input levels |
| pad_out | output | NUM_PINS | Pad output levels |
| pad_oe | output | NUM_PINS | Pad output enables |
| pad_pull | output | 2*NUM_PINS | Weak-pull selection, two bits per pin |

## Verification
Some properties are checked on every cycle. The synchronizer output must equal the pad input from two edges earlier. Any write that configures a pin as a GPIO output, or selects a reserved use, must produce the matching enable on the next cycle. Out-of-range addresses must read zero and leave the pad controls unchanged. The captured ownership bits must stay fixed once loaded. Other behaviour needs the bench's scenarios: the reset values, the exact packing and zero bits of each word, the ownership words after a write attempt, the masking of the input bit when sensing is disabled, and the decoding of neighbouring pins' addresses.

// File: rtl/pincfg_pkg.sv
`timescale 1ns/1ps
package pincfg_pkg;
  typedef enum logic [1:0] {SEL_NONE, SEL_OWN, SEL_CFGA, SEL_CFGB} sel_e;

  localparam int unsigned CFG_BASE  = 32'h100;
  localparam int unsigned CFG_STEP  = 8;
  localparam int          B_DRIVE   = 31;
  localparam int          B_SENSE   = 30;
  localparam int          B_ISIN    = 2;
  localparam int          B_NOSENSE = 2;
  localparam logic [1:0]  USE_GPIO  = 2'd1;
endpackage

// File: rtl/pincfg_addr_dec.sv
`timescale 1ns/1ps
module pincfg_addr_dec
  import pincfg_pkg::*;
#(
  parameter int NUM_PINS = 95,
  parameter int ADDR_W   = 12,
  parameter int PIN_W    = 7,
  parameter int WORD_W   = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel,
  output logic [PIN_W-1:0]  pin,
  output logic [WORD_W-1:0] word
);
  localparam int unsigned OWN_WORDS = (NUM_PINS + 31) / 32;
  localparam int unsigned OWN_END   = OWN_WORDS * 4;
  localparam int unsigned CFG_END   = CFG_BASE + NUM_PINS * CFG_STEP;

  logic [31:0] a32;
  logic [31:0] off;

  assign a32 = 32'(addr);
  assign off = a32 - CFG_BASE;

  always_comb begin
    sel  = SEL_NONE;
    pin  = '0;
    word = '0;
    if (a32[1:0] == 2'b00) begin
      if (a32 < OWN_END) begin
        sel  = SEL_OWN;
        word = WORD_W'(a32 >> 2);
      end else if (a32 >= CFG_BASE && a32 < CFG_END) begin
        pin = PIN_W'(off >> 3);
        sel = off[2] ? SEL_CFGB : SEL_CFGA;
      end
    end
  end
endmodule

// File: rtl/pincfg_own_bank.sv
`timescale 1ns/1ps
module pincfg_own_bank #(
  parameter int NUM_PINS  = 95,
  parameter int NUM_WORDS = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PINS-1:0]        strap,
  output logic [NUM_WORDS-1:0][31:0] words,
  output logic [NUM_PINS-1:0]        own_bits,
  output logic                       loaded
);
  localparam int PAD_W = NUM_WORDS * 32;

  logic [NUM_PINS-1:0] own_q;
  logic                loaded_q;
  logic                load_en;
  logic [PAD_W-1:0]    flat;

  assign load_en = !loaded_q;
  assign flat    = PAD_W'(own_q);

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign words[w] = flat[w*32 +: 32];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q    <= '0;
      loaded_q <= 1'b0;
    end else if (load_en) begin
      own_q    <= strap;
      loaded_q <= 1'b1;
    end
  end

  assign own_bits = own_q;
  assign loaded   = loaded_q;
endmodule

// File: rtl/pincfg_pin_slice.sv
`timescale 1ns/1ps
module pincfg_pin_slice
  import pincfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_a,
  input  logic        wr_b,
  input  logic [31:0] wdata,
  input  logic        pad_in,
  output logic [31:0] rd_a,
  output logic [31:0] rd_b,
  output logic        pad_out,
  output logic        pad_oe,
  output logic [1:0]  pad_pull,
  output logic        sync_out
);
  logic       drive_q, drive_d;
  logic       isin_q, isin_d;
  logic [1:0] use_q, use_d;
  logic       nosense_q, nosense_d;
  logic [1:0] pull_q, pull_d;
  logic       meta_q, sync_q;

  always_comb begin
    drive_d   = wdata[B_DRIVE];
    isin_d    = wdata[B_ISIN];
    use_d     = wdata[1:0];
    nosense_d = wdata[B_NOSENSE];
    pull_d    = wdata[1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q   <= 1'b0;
      isin_q    <= 1'b1;
      use_q     <= 2'd0;
      nosense_q <= 1'b1;
      pull_q    <= 2'd0;
      meta_q    <= 1'b0;
      sync_q    <= 1'b0;
    end else begin
      if (wr_a) begin
        drive_q <= drive_d;
        isin_q  <= isin_d;
        use_q   <= use_d;
      end
      if (wr_b) begin
        nosense_q <= nosense_d;
        pull_q    <= pull_d;
      end
      meta_q <= pad_in;
      sync_q <= meta_q;
    end
  end

  assign rd_a     = {drive_q, sync_q & ~nosense_q, 27'd0, isin_q, use_q};
  assign rd_b     = {29'd0, nosense_q, pull_q};
  assign pad_oe   = (use_q == USE_GPIO) && !isin_q;
  assign pad_out  = pad_oe & drive_q;
  assign pad_pull = pull_q;
  assign sync_out = sync_q;
endmodule

// File: rtl/pincfg_rd_mux.sv
`timescale 1ns/1ps
module pincfg_rd_mux
  import pincfg_pkg::*;
#(
  parameter int NUM_PINS  = 95,
  parameter int NUM_WORDS = 3,
  parameter int PIN_W     = 7,
  parameter int WORD_W    = 2
) (
  input  sel_e                       sel,
  input  logic [PIN_W-1:0]           pin,
  input  logic [WORD_W-1:0]          word,
  input  logic [NUM_PINS-1:0][31:0]  cfga,
  input  logic [NUM_PINS-1:0][31:0]  cfgb,
  input  logic [NUM_WORDS-1:0][31:0] own_words,
  output logic [31:0]                rdata
);
  always_comb begin
    unique case (sel)
      SEL_OWN:  rdata = own_words[word];
      SEL_CFGA: rdata = cfga[pin];
      SEL_CFGB: rdata = cfgb[pin];
      default:  rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/pin_cfg_regbank.sv
`timescale 1ns/1ps
module pin_cfg_regbank
  import pincfg_pkg::*;
#(
  parameter int NUM_PINS = 95,
  parameter int ADDR_W   = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_wr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  input  logic [NUM_PINS-1:0]     own_strap,
  input  logic [NUM_PINS-1:0]     pad_in,
  output logic [NUM_PINS-1:0]     pad_out,
  output logic [NUM_PINS-1:0]     pad_oe,
  output logic [2*NUM_PINS-1:0]   pad_pull
);
  localparam int NUM_WORDS = (NUM_PINS + 31) / 32;
  localparam int PIN_W     = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam int WORD_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  sel_e                       sel;
  logic [PIN_W-1:0]           pin;
  logic [WORD_W-1:0]          word;
  logic [NUM_PINS-1:0][31:0]  cfga;
  logic [NUM_PINS-1:0][31:0]  cfgb;
  logic [NUM_WORDS-1:0][31:0] own_words;
  logic [NUM_PINS-1:0]        own_vec;
  logic                       own_loaded;
  logic [NUM_PINS-1:0]        sync_vec;

  pincfg_addr_dec #(
    .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .PIN_W(PIN_W), .WORD_W(WORD_W)
  ) u_dec (
    .addr(bus_addr), .sel(sel), .pin(pin), .word(word)
  );

  pincfg_own_bank #(.NUM_PINS(NUM_PINS), .NUM_WORDS(NUM_WORDS)) u_own (
    .clk(clk), .rst_n(rst_n), .strap(own_strap),
    .words(own_words), .own_bits(own_vec), .loaded(own_loaded)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic hit;
    assign hit = bus_wr && (pin == PIN_W'(i));
    pincfg_pin_slice u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_a     (hit && sel == SEL_CFGA),
      .wr_b     (hit && sel == SEL_CFGB),
      .wdata    (bus_wdata),
      .pad_in   (pad_in[i]),
      .rd_a     (cfga[i]),
      .rd_b     (cfgb[i]),
      .pad_out  (pad_out[i]),
      .pad_oe   (pad_oe[i]),
      .pad_pull (pad_pull[2*i +: 2]),
      .sync_out (sync_vec[i])
    );
  end

  pincfg_rd_mux #(
    .NUM_PINS(NUM_PINS), .NUM_WORDS(NUM_WORDS), .PIN_W(PIN_W), .WORD_W(WORD_W)
  ) u_mux (
    .sel(sel), .pin(pin), .word(word), .cfga(cfga), .cfgb(cfgb),
    .own_words(own_words), .rdata(bus_rdata)
  );
endmodule

// File: rtl/pincfg_regbank_chk.sv
`timescale 1ns/1ps
module pincfg_regbank_chk
  import pincfg_pkg::*;
#(
  parameter int NUM_PINS = 95,
  parameter int ADDR_W   = 12
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic                  bus_wr,
  input logic [31:0]           bus_wdata,
  input logic [31:0]           bus_rdata,
  input logic [NUM_PINS-1:0]   pad_in,
  input logic [NUM_PINS-1:0]   pad_out,
  input logic [NUM_PINS-1:0]   pad_oe,
  input logic [2*NUM_PINS-1:0] pad_pull,
  input logic [NUM_PINS-1:0]   sync_vec,
  input logic [NUM_PINS-1:0]   own_vec,
  input logic                  own_loaded
);
  localparam int unsigned CFG_END = CFG_BASE + NUM_PINS * CFG_STEP;

  logic [1:0] cyc_q;
  logic       far_addr;

  assign far_addr = 32'(bus_addr) >= CFG_END;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc_q <= 2'd0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  a_r9_far_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    far_addr |-> bus_rdata == 32'd0);

  a_r9_far_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && far_addr) |=> ($stable(pad_oe) && $stable(pad_out) && $stable(pad_pull)));

  a_r7_own_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    own_loaded |=> $stable(own_vec));

  a_r5_two_flop_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q >= 2'd2) |-> sync_vec == $past(pad_in, 2));

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin_chk
    logic cfga_wr;
    assign cfga_wr = bus_wr && (32'(bus_addr) == CFG_BASE + i * CFG_STEP);

    a_r4_drive_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (cfga_wr && bus_wdata[1:0] == 2'd1 && !bus_wdata[2])
        |=> (pad_oe[i] && pad_out[i] == $past(bus_wdata[31])));

    a_r10_reserved_use: assert property (@(posedge clk) disable iff (!rst_n)
      (cfga_wr && bus_wdata[1]) |=> (!pad_oe[i] && !pad_out[i]));
  end
endmodule

bind pin_cfg_regbank pincfg_regbank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
  .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull(pad_pull),
  .sync_vec(sync_vec), .own_vec(own_vec), .own_loaded(own_loaded)
);

// File: tb/pin_cfg_regbank_tb.sv
`timescale 1ns/1ps
module pin_cfg_regbank_tb;
  localparam int NP = 95;
  localparam int AW = 12;

  typedef struct {
    logic [AW-1:0] addr;
    logic [31:0]   exp;
    string         tag;
  } sb_item_t;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [AW-1:0]   bus_addr;
  logic            bus_wr;
  logic [31:0]     bus_wdata;
  logic [31:0]     bus_rdata;
  logic [NP-1:0]   own_strap;
  logic [NP-1:0]   pad_in;
  logic [NP-1:0]   pad_out;
  logic [NP-1:0]   pad_oe;
  logic [2*NP-1:0] pad_pull;

  int       errors = 0;
  int       checks = 0;
  bit       done   = 1'b0;
  logic     rd_v   = 1'b0;
  sb_item_t sb_q[$];
  sb_item_t mon_item;

  always #4 clk = ~clk;

  pin_cfg_regbank #(.NUM_PINS(NP), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .own_strap(own_strap),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull(pad_pull)
  );

  function automatic logic [AW-1:0] cfg_a(int p);
    return AW'(32'h100 + p * 8);
  endfunction

  function automatic logic [AW-1:0] cfg_b(int p);
    return AW'(32'h104 + p * 8);
  endfunction

  function automatic logic [31:0] own_exp(int w);
    logic [31:0] v = '0;
    for (int b = 0; b < 32; b++) begin
      if (w * 32 + b < NP) v[b] = own_strap[w * 32 + b];
    end
    return v;
  endfunction

  // monitor: pops the expected item for each read and compares at the falling edge
  always @(negedge clk) begin
    if (rd_v) begin
      mon_item = sb_q.pop_front();
      checks++;
      if (bus_rdata !== mon_item.exp) begin
        errors++;
        $display("FAIL %s addr=0x%h actual=0x%h expected=0x%h",
                 mon_item.tag, mon_item.addr, bus_rdata, mon_item.exp);
      end
    end
  end

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_addr = AW'(12'hFFC);
  endtask

  task automatic bus_read(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
    sb_item_t it;
    @(posedge clk); #1;
    it.addr = a; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    bus_addr = a; rd_v = 1'b1;
    @(negedge clk); #1;
    rd_v = 1'b0;
  endtask

  task automatic chk_vec(input string tag, input logic [2*NP-1:0] act, input logic [2*NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%h expected=0x%h", tag, act, exp);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [NP-1:0]   oe_exp;
    logic [NP-1:0]   out_exp;
    logic [2*NP-1:0] pull_exp;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; pad_in = '0;
    for (int i = 0; i < NP; i++) own_strap[i] = ((i * 7) % 5) != 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    bus_read(cfg_a(0),  32'h4, "R1 cfgA pin0");
    bus_read(cfg_b(0),  32'h4, "R1 cfgB pin0");
    bus_read(cfg_a(47), 32'h4, "R1 cfgA pin47");
    bus_read(cfg_b(94), 32'h4, "R1 cfgB pin94");
    chk_vec("R1 pad_oe",  2*NP'(pad_oe), '0);
    chk_vec("R1 pad_out", 2*NP'(pad_out), '0);

    // R7 / R8 ownership words, write attempt ignored
    bus_read(12'h000, own_exp(0), "R7 own word0");
    bus_read(12'h004, own_exp(1), "R7 own word1");
    bus_read(12'h008, own_exp(2), "R8 own word2 upper bits zero");
    bus_write(12'h000, 32'hFFFF_FFFF);
    bus_write(12'h008, 32'hFFFF_FFFF);
    bus_read(12'h000, own_exp(0), "R7 own word0 after write");
    bus_read(12'h008, own_exp(2), "R8 own word2 after write");

    // R2 / R10 all ones: reserved use, fields read back, bit 30 not written
    bus_write(cfg_a(3), 32'hFFFF_FFFF);
    bus_read(cfg_a(3), 32'h8000_0007, "R2 cfgA pin3 readback");
    chk_vec("R10 reserved use no oe", 2*NP'(pad_oe), '0);
    bus_write(cfg_a(3), 32'h0000_0002);
    bus_read(cfg_a(3), 32'h0000_0002, "R10 use 2 stored");
    chk_vec("R10 use 2 no oe", 2*NP'(pad_oe), '0);

    // R4 output enable and drive level
    bus_write(cfg_a(3), 32'h8000_0001);
    oe_exp = '0; out_exp = '0; oe_exp[3] = 1'b1; out_exp[3] = 1'b1;
    chk_vec("R4 oe pin3",  2*NP'(pad_oe),  2*NP'(oe_exp));
    chk_vec("R4 out pin3", 2*NP'(pad_out), 2*NP'(out_exp));
    bus_write(cfg_a(94), 32'h0000_0001);
    oe_exp[94] = 1'b1;
    chk_vec("R4 oe pin94 low level", 2*NP'(pad_oe),  2*NP'(oe_exp));
    chk_vec("R4 out pin94 low level", 2*NP'(pad_out), 2*NP'(out_exp));
    bus_write(cfg_a(3), 32'h8000_0005);
    oe_exp[3] = 1'b0; out_exp[3] = 1'b0;
    chk_vec("R4 input dir drops oe", 2*NP'(pad_oe),  2*NP'(oe_exp));
    chk_vec("R4 input dir drops out", 2*NP'(pad_out), 2*NP'(out_exp));

    // R2 neighbour decode
    bus_write(cfg_a(46), 32'h0000_0001);
    bus_read(cfg_a(47), 32'h4, "R2 pin47 untouched by pin46 write");
    bus_read(cfg_b(46), 32'h4, "R2 cfgB pin46 untouched by cfgA write");

    // R3 second word and pull outputs
    bus_write(cfg_b(10), 32'hFFFF_FFFF);
    bus_read(cfg_b(10), 32'h7, "R3 cfgB pin10 all ones");
    pull_exp = '0; pull_exp[21:20] = 2'd3;
    chk_vec("R3 pull pin10", pad_pull, pull_exp);
    bus_write(cfg_b(10), 32'h2);
    bus_read(cfg_b(10), 32'h2, "R3 cfgB pin10 sensing on");
    pull_exp[21:20] = 2'd2;
    chk_vec("R3 pull pin10 two", pad_pull, pull_exp);

    // R5 two-edge synchronizer and sensing gate
    @(posedge clk); #1 pad_in[10] = 1'b1;
    bus_read(cfg_a(10), 32'h0000_0004, "R5 one edge not yet visible");
    bus_read(cfg_a(10), 32'h4000_0004, "R5 visible after two edges");
    bus_write(cfg_b(10), 32'h4);
    bus_read(cfg_a(10), 32'h0000_0004, "R5 sensing disabled reads 0");

    // R6 bit 30 ignores writes
    bus_write(cfg_b(11), 32'h0);
    bus_write(cfg_a(11), 32'h4000_0004);
    bus_read(cfg_a(11), 32'h0000_0004, "R6 bit30 write ignored");

    // R9 outside the map
    bus_read(12'h07C, 32'h0, "R9 routing word");
    bus_read(12'h080, 32'h0, "R9 status word");
    bus_read(12'h090, 32'h0, "R9 enable word");
    bus_read(12'h00C, 32'h0, "R9 past ownership");
    bus_read(12'h3F8, 32'h0, "R9 past last pin");
    bus_read(12'h101, 32'h0, "R9 unaligned");
    oe_exp = pad_oe;
    bus_write(12'h101, 32'hFFFF_FFFF);
    bus_write(12'h3F8, 32'hFFFF_FFFF);
    bus_read(cfg_a(0), 32'h4, "R9 unaligned write ignored");
    chk_vec("R9 pads unchanged", 2*NP'(pad_oe), 2*NP'(oe_exp));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule